// File: doc/BRIEF.md
# Partial Row Buffer Hit Classifier

This block watches the request stream of a memory controller and measures how much locality a small, sliced row buffer would capture. Each request address is split into channel, bank, row and column fields under one of two mappings selected by a static input. Row interleaving keeps consecutive addresses in one row of one bank. Block interleaving spreads consecutive 64-byte cache blocks over channels and banks.

One tag is kept for each bank of each channel. The buffer of a bank holds only a slice of a row: the per-chip segment of `SEG_BYTES` bytes. The tag therefore holds the row together with the upper column bits that pick the slice. Every request is classified against the tag of its bank as a hit, a miss to an empty buffer, or a conflict. The tag is then loaded with the request's slice. Two saturating counters record accesses and hits, so software or a performance monitor can read the hit rate directly.

The default geometry is 2 channels of 8 banks each, rank rows of 8 KB (1 KB per chip across 8 chips), 64-byte blocks and 32-bit addresses. Scheduling, timing checks and data movement are handled elsewhere.

Top module: `partial_rowbuf_classifier`

## Requirements
- R1: With `map_block_i`=0, the address bits split as follows: [5:0] block offset, [12:6] column (block index within the row), [13] channel, [16:14] bank, [31:17] row.
- R2: With `map_block_i`=1, the address bits split as follows: [5:0] offset, [6] channel, [9:7] bank, [16:10] column, [31:17] row, so that consecutive blocks land in different channel/bank pairs.
- R3: After reset, `res_valid_o` is 0, both counters read 0, and every bank tag is empty.
- R4: A request to a bank whose tag is empty is classified as empty (`res_kind_o`=1), and it loads that tag.
- R5: A request is a hit (`res_kind_o`=0) only when its row and its segment index both equal the tag of its bank. The segment index is column / (`SEG_BYTES`/8), which is column/8 for the default of 64.
- R6: A request to a bank with a valid tag that does not match is a conflict (`res_kind_o`=2), and the tag is replaced by the new row and segment.
- R7: With `SEG_BYTES`=8 the segment is a single block. Two requests hit only if they fall in the same 64-byte block, and any two bytes inside one block do hit.
- R8: The class and the decoded fields appear registered, with `res_valid_o`=1 exactly one cycle after a cycle in which `req_valid_i`=1, and `res_valid_o`=0 otherwise. The tag update takes effect at that same edge, so a back-to-back request sees it.
- R9: `acc_cnt_o` increments by one per request and `hit_cnt_o` by one per hit. Both counters change at the same edge as the result.
- R10: Each counter saturates at its all-ones value (`CNT_W` bits).
- R11: `cnt_clear_i` zeroes both counters at the next edge and takes priority over a request in the same cycle. That request is still classified and still updates the tag.
- R12: A request changes only the tag of its own channel/bank pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_block_i | input | 1 | Static mapping select: 0 row interleaved, 1 block interleaved |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Physical byte address of the request |
| cnt_clear_i | input | 1 | Synchronous clear of both counters |
| res_valid_o | output | 1 | Registered result valid |
| res_kind_o | output | 2 | 0 hit, 1 empty miss, 2 conflict |
| res_ch_o | output | CH_W | Decoded channel |
| res_bank_o | output | BK_W | Decoded bank |
| res_row_o | output | ROW_W | Decoded row |
| res_col_o | output | COL_W | Decoded column (block index in row) |
| hit_cnt_o | output | CNT_W | Saturating hit count |
| acc_cnt_o | output | CNT_W | Saturating access count |

## Verification
The bench goes after the points where the slice, rather than the whole row, decides the outcome. Sequential sweeps cross segment boundaries inside one row, where a design that tagged only the row would report hits instead of conflicts. Block-interleaved sweeps and random traffic with few rows check that each bank keeps its own tag and that a first touch is counted as empty rather than as a conflict. A second instance with an 8-byte segment and 4-bit counters checks exact-block hits, saturation of both counters, and clear winning over a same-cycle request; a wrong priority or a counter that wraps would show up as a mismatched count.

// File: rtl/rbhc_pkg.sv
package rbhc_pkg;
  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_EMPTY    = 2'd1,
    CLS_CONFLICT = 2'd2
  } rb_class_e;
endpackage

// File: rtl/rbhc_addr_map.sv
module rbhc_addr_map #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned CH_W   = 1,
  parameter int unsigned BK_W   = 3,
  parameter int unsigned COL_W  = 7,
  parameter int unsigned SEG_W  = 4,
  localparam int unsigned ROW_W = ADDR_W - OFF_W - CH_W - BK_W - COL_W,
  localparam int unsigned TAG_W = ROW_W + SEG_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_block_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [BK_W-1:0]   bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned RI_CH  = OFF_W + COL_W;
  localparam int unsigned RI_BK  = RI_CH + CH_W;
  localparam int unsigned BI_BK  = OFF_W + CH_W;
  localparam int unsigned BI_COL = BI_BK + BK_W;

  logic unused_offset;
  assign unused_offset = ^addr_i[OFF_W-1:0];

  assign row_o = addr_i[ADDR_W-1 -: ROW_W];

  always_comb begin
    if (map_block_i) begin
      ch_o   = addr_i[OFF_W +: CH_W];
      bank_o = addr_i[BI_BK +: BK_W];
      col_o  = addr_i[BI_COL +: COL_W];
    end else begin
      col_o  = addr_i[OFF_W +: COL_W];
      ch_o   = addr_i[RI_CH +: CH_W];
      bank_o = addr_i[RI_BK +: BK_W];
    end
  end

  // Slice select = upper column bits; a full-row buffer has none.
  generate
    if (SEG_W == 0) begin : g_full_row
      assign tag_o = row_o;
    end else begin : g_slice
      assign tag_o = {row_o, col_o[COL_W-1 -: SEG_W]};
    end
  endgenerate
endmodule

// File: rtl/rbhc_tag_table.sv
module rbhc_tag_table
  import rbhc_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 19,
  localparam int unsigned NENT = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output rb_class_e        cls_o
);
  logic [NENT-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [NENT];

  always_comb begin
    if (!valid_q[idx_i])           cls_o = CLS_EMPTY;
    else if (tag_q[idx_i] == tag_i) cls_o = CLS_HIT;
    else                           cls_o = CLS_CONFLICT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NENT; i++) tag_q[i] <= '0;
    end else if (req_i) begin
      valid_q[idx_i] <= 1'b1;
      tag_q[idx_i]   <= tag_i;
    end
  end

  AST_TAG_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_q[$past(idx_i)]); // R4
  AST_REPEAT_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!(req_i && idx_i == $past(idx_i) && tag_i == $past(tag_i)) || cls_o == CLS_HIT)); // R5
  AST_OTHER_BANK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && idx_i != 0) |=> $stable(tag_q[0])); // R12
endmodule

// File: rtl/rbhc_sat_counter.sv
module rbhc_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R11
  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/partial_rowbuf_classifier.sv
module partial_rowbuf_classifier
  import rbhc_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned NUM_CH         = 2,
  parameter int unsigned NUM_BANK       = 8,
  parameter int unsigned CHIPS          = 8,
  parameter int unsigned CHIP_IO_BYTES  = 8,
  parameter int unsigned CHIP_ROW_BYTES = 1024,
  parameter int unsigned SEG_BYTES      = 64,
  parameter int unsigned CNT_W          = 32,
  localparam int unsigned OFF_W = $clog2(CHIPS * CHIP_IO_BYTES),
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned BK_W  = $clog2(NUM_BANK),
  localparam int unsigned COL_W = $clog2(CHIP_ROW_BYTES / CHIP_IO_BYTES),
  localparam int unsigned SEG_W = $clog2(CHIP_ROW_BYTES / SEG_BYTES),
  localparam int unsigned ROW_W = ADDR_W - OFF_W - CH_W - BK_W - COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_block_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              cnt_clear_i,
  output logic              res_valid_o,
  output logic [1:0]        res_kind_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic [BK_W-1:0]   res_bank_o,
  output logic [ROW_W-1:0]  res_row_o,
  output logic [COL_W-1:0]  res_col_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  acc_cnt_o
);
  localparam int unsigned TAG_W = ROW_W + SEG_W;
  localparam int unsigned IDX_W = CH_W + BK_W;

  logic [CH_W-1:0]  ch_d;
  logic [BK_W-1:0]  bank_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic [TAG_W-1:0] tag_d;
  rb_class_e        cls_d;

  rbhc_addr_map #(
    .ADDR_W (ADDR_W), .OFF_W (OFF_W), .CH_W (CH_W),
    .BK_W   (BK_W),   .COL_W (COL_W), .SEG_W (SEG_W)
  ) i_addr_map (
    .addr_i      (req_addr_i),
    .map_block_i (map_block_i),
    .ch_o        (ch_d),
    .bank_o      (bank_d),
    .row_o       (row_d),
    .col_o       (col_d),
    .tag_o       (tag_d)
  );

  rbhc_tag_table #(
    .IDX_W (IDX_W), .TAG_W (TAG_W)
  ) i_tag_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_valid_i),
    .idx_i  ({ch_d, bank_d}),
    .tag_i  (tag_d),
    .cls_o  (cls_d)
  );

  rbhc_sat_counter #(.W (CNT_W)) i_acc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clear_i),
    .inc_i  (req_valid_i),
    .cnt_o  (acc_cnt_o)
  );

  rbhc_sat_counter #(.W (CNT_W)) i_hit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clear_i),
    .inc_i  (req_valid_i && cls_d == CLS_HIT),
    .cnt_o  (hit_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_kind_o  <= 2'd0;
      res_ch_o    <= '0;
      res_bank_o  <= '0;
      res_row_o   <= '0;
      res_col_o   <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        res_kind_o <= cls_d;
        res_ch_o   <= ch_d;
        res_bank_o <= bank_d;
        res_row_o  <= row_d;
        res_col_o  <= col_d;
      end
    end
  end

  AST_RES_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R8
  AST_RES_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o); // R8
  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_kind_o != 2'd3); // R6
  AST_HIT_LE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_o <= acc_cnt_o); // R9
endmodule

// File: tb/test_partial_rowbuf_classifier.sv
module test_partial_rowbuf_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // main instance: default geometry, 64 B segment
  logic        mode = 1'b0, req_v = 1'b0, clr = 1'b0;
  logic [31:0] addr = '0;
  logic        res_v;
  logic [1:0]  kind;
  logic        ch;
  logic [2:0]  bank;
  logic [14:0] row;
  logic [6:0]  col;
  logic [31:0] hit_c, acc_c;

  partial_rowbuf_classifier i_partial_rowbuf_classifier (
    .clk_i (clk), .rst_ni (rst_n), .map_block_i (mode),
    .req_valid_i (req_v), .req_addr_i (addr), .cnt_clear_i (clr),
    .res_valid_o (res_v), .res_kind_o (kind), .res_ch_o (ch),
    .res_bank_o (bank), .res_row_o (row), .res_col_o (col),
    .hit_cnt_o (hit_c), .acc_cnt_o (acc_c)
  );

  // second instance: 8 B segment, 4-bit counters
  logic        s_req_v = 1'b0, s_clr = 1'b0;
  logic [31:0] s_addr = '0;
  logic        s_res_v;
  logic [1:0]  s_kind;
  logic        s_ch;
  logic [2:0]  s_bank;
  logic [14:0] s_row;
  logic [6:0]  s_col;
  logic [3:0]  s_hit_c, s_acc_c;

  partial_rowbuf_classifier #(.SEG_BYTES (8), .CNT_W (4)) i_partial_rowbuf_classifier_sat (
    .clk_i (clk), .rst_ni (rst_n), .map_block_i (1'b0),
    .req_valid_i (s_req_v), .req_addr_i (s_addr), .cnt_clear_i (s_clr),
    .res_valid_o (s_res_v), .res_kind_o (s_kind), .res_ch_o (s_ch),
    .res_bank_o (s_bank), .res_row_o (s_row), .res_col_o (s_col),
    .hit_cnt_o (s_hit_c), .acc_cnt_o (s_acc_c)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // bench model
  bit          m_v   [16];
  longint      m_row [16];
  longint      m_seg [16];
  longint      m_acc = 0, m_hit = 0;

  task automatic send(input longint a, input bit blk, input bit do_clr);
    longint b, e_col, e_ch, e_bk, e_row, e_seg;
    int idx, e_kind;
    b = a / 64;
    e_row = a / 131072;
    if (blk) begin
      e_ch = b % 2; e_bk = (b / 2) % 8; e_col = (b / 16) % 128;
    end else begin
      e_col = b % 128; e_ch = (b / 128) % 2; e_bk = (b / 256) % 8;
    end
    e_seg = e_col / 8;
    idx = int'(e_ch * 8 + e_bk);
    if (!m_v[idx]) e_kind = 1;
    else if (m_row[idx] == e_row && m_seg[idx] == e_seg) e_kind = 0;
    else e_kind = 2;
    mode = blk; addr = a[31:0]; req_v = 1'b1; clr = do_clr;
    @(negedge clk);
    m_v[idx] = 1'b1; m_row[idx] = e_row; m_seg[idx] = e_seg;
    if (do_clr) begin m_acc = 0; m_hit = 0; end
    else begin m_acc++; if (e_kind == 0) m_hit++; end
    check(res_v == 1'b1, "R8 valid", res_v, 1);
    case (e_kind)
      0: check(kind == 2'd0, "R5 hit", kind, 0);
      1: check(kind == 2'd1, "R4 empty", kind, 1);
      default: check(kind == 2'd2, "R6 conflict", kind, 2);
    endcase
    if (blk) check(ch == e_ch && bank == e_bk && col == e_col && row == e_row,
                   "R2 fields", {ch, bank, col}, e_ch * 1024 + e_bk * 128 + e_col);
    else     check(ch == e_ch && bank == e_bk && col == e_col && row == e_row,
                   "R1 fields", {ch, bank, col}, e_ch * 1024 + e_bk * 128 + e_col);
    check(acc_c == m_acc, do_clr ? "R11 acc" : "R9 acc", acc_c, m_acc);
    check(hit_c == m_hit, do_clr ? "R11 hit" : "R9 hit", hit_c, m_hit);
    req_v = 1'b0; clr = 1'b0;
  endtask

  task automatic s_send(input longint a, input int e_kind, input int e_acc, input int e_hit, input bit do_clr);
    s_addr = a[31:0]; s_req_v = 1'b1; s_clr = do_clr;
    @(negedge clk);
    check(s_kind == e_kind[1:0], "R7 kind", s_kind, e_kind);
    check(s_acc_c == e_acc[3:0], "R10 acc", s_acc_c, e_acc);
    check(s_hit_c == e_hit[3:0], "R10 hit", s_hit_c, e_hit);
    s_req_v = 1'b0; s_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2345;
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state
    check(res_v == 1'b0, "R3 valid", res_v, 0);
    check(acc_c == 0 && hit_c == 0, "R3 counters", acc_c + hit_c, 0);
    check(s_acc_c == 0, "R3 small acc", s_acc_c, 0);

    // R1: row-interleaved sequential sweep, byte step inside blocks varied
    for (int i = 0; i < 2048; i++) send(longint'(i) * 64 + (i % 64), 1'b0, 1'b0);
    @(negedge clk);
    check(res_v == 1'b0, "R8 idle", res_v, 0);

    // R2: block-interleaved sweep in another row
    for (int i = 0; i < 1024; i++) send((longint'(3) << 17) + longint'(i) * 64, 1'b1, 1'b0);
    // R2: same blocks again, stride that changes segment each pass
    for (int i = 0; i < 512; i++) send((longint'(3) << 17) + longint'(i) * 64 * 7, 1'b1, 1'b0);

    // R12: bank independence, directed
    send(32'h0000_0000, 1'b0, 1'b0);
    send((longint'(5) << 17) + (1 << 14), 1'b0, 1'b0);
    send(32'h0000_0040, 1'b0, 1'b0);  // bank 0 again: expect hit (R12)

    // random mix with few rows so hits and conflicts both occur
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send({13'd0, lfsr[18:17] & 2'b01, lfsr[16:0]}, lfsr[25], 1'b0);
    end

    // R11: clear wins over a same-cycle request, tag still updated
    send(32'h0002_0000, 1'b0, 1'b1);
    send(32'h0002_0008, 1'b0, 1'b0);  // hit after clear -> counts 1/1

    // R7, R10: small instance
    s_send(0,  1, 1, 0, 1'b0);
    s_send(8,  0, 2, 1, 1'b0);   // same block: hit
    s_send(64, 2, 3, 1, 1'b0);   // next block: conflict
    s_send(96, 0, 4, 2, 1'b0);   // same block as 64: hit
    for (int i = 0; i < 16; i++)
      s_send(64, 0, (5 + i > 15) ? 15 : 5 + i, (3 + i > 15) ? 15 : 3 + i, 1'b0);
    s_send(64, 0, 0, 0, 1'b1);   // R11 clear beats request
    s_send(72, 0, 1, 1, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule